// File: doc/BRIEF.md
# Complex-Serial Parallel FIR Filter

This block filters a stream of complex samples whose two halves share one input bus. The real part arrives in the cycle marked by the input strobe, and the imaginary part follows in the next clock. The block commits each pair to a complex tap line and multiplies every tap by a complex coefficient fixed at build time, one multiplier pair per tap. It sums the products in a binary adder tree at full precision.

Each accepted sample yields one complex result. The result leaves on a single output bus, real part first with a flag raised and imaginary part in the following clock with the flag low. One sample every two clocks is the highest rate, so the block keeps up with an input bus running at half the clock rate. Cycles without a strobe leave the filter state untouched.

Top module: `cfir_cs_top`

## Requirements
- R1: After reset the tap line holds zero samples, `res_out` is 0 and `res_is_real` is low. The first result after reset therefore depends only on the first sample.
- R2: The value on `samp_in` in a cycle with `sample_strobe` high is the real part, and the value in the next cycle is the imaginary part. A strobe seen during that imaginary cycle is ignored and does not start a new sample.
- R3: When no strobe is accepted, the tap line keeps its contents, whatever `samp_in` carries.
- R4: The real result equals the sum over k of (xr[k]·cr[k] − xi[k]·ci[k]). Here x[0] is the newest accepted sample, and the value is full-precision two's complement of width DW+CW+1+clog2(TAPS).
- R5: The imaginary result equals the sum over k of (xr[k]·ci[k] + xi[k]·cr[k]), at the same width and in the same format.
- R6: If the strobe is accepted in cycle t, the real result is on `res_out` with `res_is_real` high in cycle t+3.
- R7: The imaginary result is on `res_out` in cycle t+4, with `res_is_real` low.
- R8: `res_is_real` is high exactly once per accepted sample and is low otherwise. Between results, `res_out` keeps its last value.
- R9: Samples accepted every two clocks, back to back, each produce a correct result without loss.
- R10: Coefficients come from the parameters `COEF_RE` and `COEF_IM`. Tap k uses bits [k*CW +: CW] of each as a signed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_strobe | input | 1 | High in the cycle carrying a real part |
| samp_in | input | DW | Interleaved real/imaginary sample data, signed |
| res_out | output | DW+CW+1+clog2(TAPS) | Interleaved real/imaginary result, signed |
| res_is_real | output | 1 | High while `res_out` carries a real result |

## Verification
The bench builds the filter with three taps and 4-bit data and coefficients, so OW is 11 bits. At that size it feeds every one of the 256 possible complex input values through the line. The coefficients include the most negative and most positive codes, so every product sign and the extremes of the full-precision sum are reached. A reference convolution in the bench computes the expected values. Further passes hold the strobe high through the imaginary beat and insert gaps of junk data of varying length.

// File: rtl/cfir_pkg.sv
package cfir_pkg;

  // Which half of a complex sample the input bus is expected to carry.
  typedef enum logic {
    BEAT_RE = 1'b0,
    BEAT_IM = 1'b1
  } beat_e;

  // Full-precision result width: one complex product grows by one bit,
  // and the adder tree adds clog2(taps) bits.
  function automatic int acc_width(int dw, int cw, int taps);
    return dw + cw + 1 + $clog2(taps);
  endfunction

endpackage

// File: rtl/cfir_pair_capture.sv
module cfir_pair_capture
  import cfir_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe,
  input  logic signed [DW-1:0] din,
  output logic                 take_re,
  output logic                 commit,
  output logic signed [DW-1:0] pair_re,
  output logic signed [DW-1:0] pair_im
);

  beat_e               beat_q;
  logic signed [DW-1:0] hold_re_q;

  // A strobe only starts a sample while the real beat is expected.
  assign take_re = strobe && (beat_q == BEAT_RE);
  // The imaginary beat is always the cycle after an accepted real beat.
  assign commit  = (beat_q == BEAT_IM);
  assign pair_re = hold_re_q;
  assign pair_im = din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q    <= BEAT_RE;
      hold_re_q <= '0;
    end else if (take_re) begin
      beat_q    <= BEAT_IM;
      hold_re_q <= din;
    end else if (commit) begin
      beat_q    <= BEAT_RE;
    end
  end

endmodule

// File: rtl/cfir_tapline.sv
module cfir_tapline #(
  parameter int TAPS = 4,
  parameter int DW   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic [TAPS*DW-1:0]   taps_re,
  output logic [TAPS*DW-1:0]   taps_im,
  output logic                 fresh
);

  // Tap 0 takes the newest sample; each later tap takes its neighbour.
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          taps_re[DW-1:0] <= '0;
          taps_im[DW-1:0] <= '0;
        end else if (shift) begin
          taps_re[DW-1:0] <= in_re;
          taps_im[DW-1:0] <= in_im;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          taps_re[k*DW +: DW] <= '0;
          taps_im[k*DW +: DW] <= '0;
        end else if (shift) begin
          taps_re[k*DW +: DW] <= taps_re[(k-1)*DW +: DW];
          taps_im[k*DW +: DW] <= taps_im[(k-1)*DW +: DW];
        end
      end
    end
  end

  // Marks the cycle in which the tap line holds a newly committed sample.
  always_ff @(posedge clk) begin
    if (!rst_n) fresh <= 1'b0;
    else        fresh <= shift;
  end

endmodule

// File: rtl/cfir_cmac.sv
module cfir_cmac #(
  parameter int                 TAPS    = 4,
  parameter int                 DW      = 12,
  parameter int                 CW      = 12,
  parameter int                 OW      = 27,
  parameter logic [TAPS*CW-1:0] COEF_RE = '0,
  parameter logic [TAPS*CW-1:0] COEF_IM = '0
) (
  input  logic [TAPS*DW-1:0]   taps_re,
  input  logic [TAPS*DW-1:0]   taps_im,
  output logic signed [OW-1:0] sum_re,
  output logic signed [OW-1:0] sum_im
);

  localparam int PW  = DW + CW + 1;
  localparam int LVL = $clog2(TAPS);
  localparam int P2  = 1 << LVL;
  localparam int NN  = 2 * P2 - 1;

  // Real part of one complex product.
  function automatic logic signed [PW-1:0] prod_re(
    logic signed [DW-1:0] xr, logic signed [DW-1:0] xi,
    logic signed [CW-1:0] cr, logic signed [CW-1:0] ci);
    logic signed [PW-1:0] a;
    logic signed [PW-1:0] b;
    a = PW'(xr) * PW'(cr);
    b = PW'(xi) * PW'(ci);
    return a - b;
  endfunction

  // Imaginary part of one complex product.
  function automatic logic signed [PW-1:0] prod_im(
    logic signed [DW-1:0] xr, logic signed [DW-1:0] xi,
    logic signed [CW-1:0] cr, logic signed [CW-1:0] ci);
    logic signed [PW-1:0] a;
    logic signed [PW-1:0] b;
    a = PW'(xr) * PW'(ci);
    b = PW'(xi) * PW'(cr);
    return a + b;
  endfunction

  logic signed [OW-1:0] node_re [NN];
  logic signed [OW-1:0] node_im [NN];

  // Leaves: one complex multiplier per tap; padding leaves are zero.
  for (genvar i = 0; i < P2; i++) begin : g_leaf
    if (i < TAPS) begin : g_mul
      logic signed [PW-1:0] p_re;
      logic signed [PW-1:0] p_im;
      assign p_re = prod_re($signed(taps_re[i*DW +: DW]), $signed(taps_im[i*DW +: DW]),
                            $signed(COEF_RE[i*CW +: CW]), $signed(COEF_IM[i*CW +: CW]));
      assign p_im = prod_im($signed(taps_re[i*DW +: DW]), $signed(taps_im[i*DW +: DW]),
                            $signed(COEF_RE[i*CW +: CW]), $signed(COEF_IM[i*CW +: CW]));
      assign node_re[P2-1+i] = OW'(p_re);
      assign node_im[P2-1+i] = OW'(p_im);
    end else begin : g_pad
      assign node_re[P2-1+i] = '0;
      assign node_im[P2-1+i] = '0;
    end
  end

  // Binary adder tree, node i sums its two children.
  for (genvar i = 0; i < P2 - 1; i++) begin : g_add
    assign node_re[i] = node_re[2*i+1] + node_re[2*i+2];
    assign node_im[i] = node_im[2*i+1] + node_im[2*i+2];
  end

  assign sum_re = node_re[0];
  assign sum_im = node_im[0];

endmodule

// File: rtl/cfir_serializer.sv
module cfir_serializer #(
  parameter int OW = 27
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic signed [OW-1:0] in_re,
  input  logic signed [OW-1:0] in_im,
  output logic signed [OW-1:0] dout,
  output logic                 is_real
);

  logic signed [OW-1:0] im_hold_q;
  logic                 im_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout      <= '0;
      is_real   <= 1'b0;
      im_hold_q <= '0;
      im_pend_q <= 1'b0;
    end else if (load) begin
      dout      <= in_re;
      is_real   <= 1'b1;
      im_hold_q <= in_im;
      im_pend_q <= 1'b1;
    end else if (im_pend_q) begin
      dout      <= im_hold_q;
      is_real   <= 1'b0;
      im_pend_q <= 1'b0;
    end else begin
      is_real   <= 1'b0;
    end
  end

endmodule

// File: rtl/cfir_cs_top.sv
module cfir_cs_top #(
  parameter int                 TAPS    = 4,
  parameter int                 DW      = 12,
  parameter int                 CW      = 12,
  parameter logic [TAPS*CW-1:0] COEF_RE = {TAPS{CW'(1)}},
  parameter logic [TAPS*CW-1:0] COEF_IM = '0,
  localparam int                OW      = cfir_pkg::acc_width(DW, CW, TAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_strobe,
  input  logic signed [DW-1:0] samp_in,
  output logic signed [OW-1:0] res_out,
  output logic                 res_is_real
);

  // Named internal events, also watched by the bound checker.
  logic                 take_re;
  logic                 commit;
  logic                 fresh;
  logic signed [DW-1:0] pair_re;
  logic signed [DW-1:0] pair_im;
  logic [TAPS*DW-1:0]   taps_re;
  logic [TAPS*DW-1:0]   taps_im;
  logic signed [OW-1:0] sum_re;
  logic signed [OW-1:0] sum_im;

  cfir_pair_capture #(.DW(DW)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (sample_strobe),
    .din     (samp_in),
    .take_re (take_re),
    .commit  (commit),
    .pair_re (pair_re),
    .pair_im (pair_im)
  );

  cfir_tapline #(.TAPS(TAPS), .DW(DW)) u_taps (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift   (commit),
    .in_re   (pair_re),
    .in_im   (pair_im),
    .taps_re (taps_re),
    .taps_im (taps_im),
    .fresh   (fresh)
  );

  cfir_cmac #(
    .TAPS(TAPS), .DW(DW), .CW(CW), .OW(OW),
    .COEF_RE(COEF_RE), .COEF_IM(COEF_IM)
  ) u_mac (
    .taps_re (taps_re),
    .taps_im (taps_im),
    .sum_re  (sum_re),
    .sum_im  (sum_im)
  );

  cfir_serializer #(.OW(OW)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (fresh),
    .in_re   (sum_re),
    .in_im   (sum_im),
    .dout    (res_out),
    .is_real (res_is_real)
  );

endmodule

// File: rtl/cfir_cs_checker.sv
module cfir_cs_checker #(
  parameter int TW = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          take_re,
  input logic          commit,
  input logic          fresh,
  input logic          res_is_real,
  input logic [TW-1:0] taps_re,
  input logic [TW-1:0] taps_im
);

  AST_IM_BEAT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) take_re |=> commit); // R2
  AST_IM_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) take_re |=> !take_re); // R2
  AST_TAPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !commit |=> ($stable(taps_re) && $stable(taps_im))); // R3
  AST_FRESH_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n) commit |=> fresh); // R6
  AST_REAL_AFTER_FRESH: assert property (@(posedge clk) disable iff (!rst_n) fresh |=> res_is_real); // R6
  AST_REAL_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) res_is_real |-> $past(fresh)); // R8
  AST_IMAG_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n) res_is_real |=> !res_is_real); // R7

endmodule

bind cfir_cs_top cfir_cs_checker #(.TW(TAPS*DW)) u_cfir_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .take_re     (take_re),
  .commit      (commit),
  .fresh       (fresh),
  .res_is_real (res_is_real),
  .taps_re     (taps_re),
  .taps_im     (taps_im)
);

// File: tb/cfir_cs_top_bench.sv
`timescale 1ns/1ps
module cfir_cs_top_bench;

  localparam int TAPS = 3;
  localparam int DW   = 4;
  localparam int CW   = 4;
  localparam int OW   = DW + CW + 1 + 2;
  // Tap k at bits [k*4 +: 4]: re = 7, -8, 2 ; im = -8, -3, 5
  localparam logic [11:0] BC_RE = 12'h287;
  localparam logic [11:0] BC_IM = 12'h5D8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 sample_strobe = 1'b0;
  logic signed [DW-1:0] samp_in = '0;
  logic signed [OW-1:0] res_out;
  logic                 res_is_real;

  always #4 clk = ~clk;

  cfir_cs_top #(
    .TAPS(TAPS), .DW(DW), .CW(CW), .COEF_RE(BC_RE), .COEF_IM(BC_IM)
  ) u_cfir_cs_top (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_strobe (sample_strobe),
    .samp_in       (samp_in),
    .res_out       (res_out),
    .res_is_real   (res_is_real)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  bit    mon_on = 1'b0;
  bit    done   = 1'b0;
  string ph     = "R1";

  int hr [TAPS];
  int hi [TAPS];
  int q_due [$];
  int q_re  [$];
  int q_im  [$];
  bit im_due = 1'b0;
  int im_exp = 0;
  int last   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int coef_r(int k);
    return int'($signed(BC_RE[k*4 +: 4]));
  endfunction

  function automatic int coef_i(int k);
    return int'($signed(BC_IM[k*4 +: 4]));
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Sends one complex sample; the strobe may stay high in the imaginary beat.
  task automatic send(int re, int im, bit hold_strobe, int gap);
    int sr;
    int si;
    @(negedge clk);
    samp_in       = re[3:0];
    sample_strobe = 1'b1;
    for (int k = TAPS - 1; k > 0; k--) begin
      hr[k] = hr[k-1];
      hi[k] = hi[k-1];
    end
    hr[0] = re;
    hi[0] = im;
    sr = 0;
    si = 0;
    for (int k = 0; k < TAPS; k++) begin
      sr += hr[k] * coef_r(k) - hi[k] * coef_i(k);
      si += hr[k] * coef_i(k) + hi[k] * coef_r(k);
    end
    q_due.push_back(cyc + 3);
    q_re.push_back(sr);
    q_im.push_back(si);
    @(negedge clk);
    samp_in       = im[3:0];
    sample_strobe = hold_strobe;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      sample_strobe = 1'b0;
      samp_in       = DW'($urandom);
    end
  endtask

  // Output monitor: every cycle is checked against the reference schedule.
  always @(negedge clk) begin
    if (mon_on) begin
      if (q_due.size() > 0 && q_due[0] < cyc) begin
        chk(1'b0, {ph, " R6 missed result"}, cyc, q_due[0]);
        void'(q_due.pop_front());
        void'(q_re.pop_front());
        void'(q_im.pop_front());
      end
      if (im_due) begin
        chk(res_is_real == 1'b0, {ph, " R7 flag"}, int'(res_is_real), 0);
        chk(int'(res_out) == im_exp, {ph, " R5 R7 imag"}, int'(res_out), im_exp);
        last   = im_exp;
        im_due = 1'b0;
      end else if (q_due.size() > 0 && q_due[0] == cyc) begin
        chk(res_is_real == 1'b1, {ph, " R6 flag"}, int'(res_is_real), 1);
        chk(int'(res_out) == q_re[0], {ph, " R4 R6 real"}, int'(res_out), q_re[0]);
        im_exp = q_im[0];
        im_due = 1'b1;
        void'(q_due.pop_front());
        void'(q_re.pop_front());
        void'(q_im.pop_front());
      end else begin
        chk(res_is_real == 1'b0, {ph, " R8 idle flag"}, int'(res_is_real), 0);
        chk(int'(res_out) == last, {ph, " R8 hold"}, int'(res_out), last);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    for (int k = 0; k < TAPS; k++) begin
      hr[k] = 0;
      hi[k] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(res_is_real == 1'b0, "R1 flag after reset", int'(res_is_real), 0);
    chk(int'(res_out) == 0, "R1 output after reset", int'(res_out), 0);
    mon_on = 1'b1;

    ph = "R1 R10";
    send(3, -2, 1'b0, 0);
    send(-8, 7, 1'b0, 0);

    ph = "R4 R5 R9 R10";
    for (int r = -8; r < 8; r++) begin
      for (int i = -8; i < 8; i++) begin
        send(r, i, 1'b0, 0);
      end
    end

    ph = "R2";
    for (int k = 0; k < 40; k++) begin
      send(((k * 5) % 16) - 8, ((k * 11 + 3) % 16) - 8, 1'b1, 0);
    end

    ph = "R3 R8";
    for (int k = 0; k < 60; k++) begin
      send(((k * 7 + 1) % 16) - 8, ((k * 3 + 5) % 16) - 8, k[0], k % 4);
    end

    ph = "R3";
    @(negedge clk);
    sample_strobe = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      samp_in = DW'($urandom);
    end
    send(-8, -8, 1'b0, 0);
    @(negedge clk);
    sample_strobe = 1'b0;
    repeat (10) @(negedge clk);
    chk(q_due.size() == 0, "R8 all results delivered", q_due.size(), 0);
    done = 1'b1;
    report();
  end

endmodule